// File: doc/BRIEF.md
# DMA Channel Arm and Abort Control

This block keeps the enable ("arm") state of five DMA channels behind one 8-bit control register. It also latches per-channel completion interrupts. Software writes the register in one of two ways. With the top bit clear, the write loads the five low bits as the new arm pattern. With the top bit set, the same five low bits select the channels to cancel. Those channels are disarmed, and each one receives a single-cycle abort pulse.

The channel engines report two things per channel: a terminal-count strobe and whether the channel runs in a repeating mode. A non-repeating channel that reaches its count disarms itself. A repeating channel stays armed. In both cases the channel's interrupt flag is set if its mask allows it. Each flag is sticky and stays set until its own clear strobe arrives. A transfer request from an engine is passed on only while that channel is armed.

Top module: `dmaArmCtrl`

## Requirements
- R1: After reset, `armState`, `irqFlag` and `abortPulse` are all zero, and `regRdData` reads 0x00.
- R2: A register write with bit 7 at 0 loads `regWrData[4:0]` into `armState` one cycle later. `regRdData` always shows `{3'b000, armState}`, so bits 7:5 read 0.
- R3: `xferEn[i]` is 1 exactly when `xferReq[i]` is 1 and channel i is armed, in the same cycle.
- R4: A register write with bit 7 at 1 clears the arm bit of every channel whose bit in `regWrData[4:0]` is 1. The other channels keep their arm bits.
- R5: In the cycle after an abort write, `abortPulse` equals the `regWrData[4:0]` of that write, and it is zero in every other cycle.
- R6: A `tcReached` strobe on an armed channel with `repeatMode` 0 clears that channel's arm bit one cycle later.
- R7: A `tcReached` strobe on an armed channel with `repeatMode` 1 leaves its arm bit set.
- R8: A `tcReached` strobe on a channel that is not armed changes neither its arm bit nor its interrupt flag.
- R9: A terminal count on an armed channel sets `irqFlag[i]` one cycle later when `irqMask[i]` is 1. It leaves the flag unchanged when `irqMask[i]` is 0.
- R10: `irqFlag[i]` holds until `irqClr[i]` is 1. If a new interrupt and a clear arrive for the same channel in the same cycle, the flag ends up set.
- R11: If a self-clear (R6) and a software write hit the same channel in the same cycle, the channel ends up disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read value |
| xferReq | input | 5 | Per-channel transfer request from engines |
| xferEn | output | 5 | Per-channel transfer permitted |
| tcReached | input | 5 | Per-channel terminal-count strobe |
| repeatMode | input | 5 | Per-channel repeating-mode flag |
| irqMask | input | 5 | Per-channel interrupt enable |
| irqClr | input | 5 | Per-channel interrupt flag clear strobe |
| armState | output | 5 | Per-channel arm bits |
| abortPulse | output | 5 | Per-channel single-cycle abort |
| irqFlag | output | 5 | Per-channel sticky interrupt request |

## Verification
Two pairs of events can land in the same cycle, and each pair is forced deliberately.

- A software write and a non-repeating terminal count on the same channel. The bench drives a write that re-arms every channel in the same cycle as a terminal count on one armed, non-repeating channel. It then expects that channel, and only that channel, to read back as disarmed.
- An interrupt set and an interrupt clear on the same channel. The bench asserts `irqClr` in the same cycle as a terminal count, and the flag must remain set.

A reference model in the bench computes every expected value from the requirement rules alone.

// File: rtl/dmaArmPkg.sv
package dmaArmPkg;
  parameter int NumCh = 5;
  parameter int RegW = 8;
  parameter int AbortBit = 7;

  typedef struct packed {
    logic             wrLoad;
    logic             wrAbort;
    logic [NumCh-1:0] wrMask;
    logic [NumCh-1:0] autoClr;
    logic [NumCh-1:0] irqSet;
  } armStrobe_t;
endpackage

// File: rtl/dmaArmDecode.sv
module dmaArmDecode
  import dmaArmPkg::*;
(
  input  logic             regWrEn,
  input  logic [RegW-1:0]  regWrData,
  input  logic [NumCh-1:0] tcReached,
  input  logic [NumCh-1:0] repeatMode,
  input  logic [NumCh-1:0] irqMask,
  input  logic [NumCh-1:0] armCur,
  output armStrobe_t       strobe
);
  logic [NumCh-1:0] tcEvent;
  logic [RegW-1:0]  unusedWrBits;

  assign unusedWrBits = regWrData;
  assign tcEvent = tcReached & armCur;

  always_comb begin
    strobe.wrLoad  = regWrEn & ~regWrData[AbortBit];
    strobe.wrAbort = regWrEn &  regWrData[AbortBit];
    strobe.wrMask  = regWrData[NumCh-1:0];
    strobe.autoClr = tcEvent & ~repeatMode;
    strobe.irqSet  = tcEvent & irqMask;
  end
endmodule

// File: rtl/dmaArmState.sv
module dmaArmState
  import dmaArmPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  armStrobe_t       strobe,
  input  logic [NumCh-1:0] irqClr,
  output logic [NumCh-1:0] armCur,
  output logic [NumCh-1:0] abortCur,
  output logic [NumCh-1:0] irqCur
);
  for (genvar ch = 0; ch < NumCh; ch++) begin : g_ch
    logic armNext;
    logic irqNext;

    always_comb begin
      armNext = armCur[ch];
      if (strobe.wrLoad)
        armNext = strobe.wrMask[ch];
      else if (strobe.wrAbort && strobe.wrMask[ch])
        armNext = 1'b0;
      if (strobe.autoClr[ch])
        armNext = 1'b0;
      irqNext = (irqCur[ch] & ~irqClr[ch]) | strobe.irqSet[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armCur[ch]   <= 1'b0;
        abortCur[ch] <= 1'b0;
        irqCur[ch]   <= 1'b0;
      end else begin
        armCur[ch]   <= armNext;
        abortCur[ch] <= strobe.wrAbort & strobe.wrMask[ch];
        irqCur[ch]   <= irqNext;
      end
    end
  end
endmodule

// File: rtl/dmaArmCtrl.sv
module dmaArmCtrl
  import dmaArmPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [RegW-1:0]  regWrData,
  output logic [RegW-1:0]  regRdData,
  input  logic [NumCh-1:0] xferReq,
  output logic [NumCh-1:0] xferEn,
  input  logic [NumCh-1:0] tcReached,
  input  logic [NumCh-1:0] repeatMode,
  input  logic [NumCh-1:0] irqMask,
  input  logic [NumCh-1:0] irqClr,
  output logic [NumCh-1:0] armState,
  output logic [NumCh-1:0] abortPulse,
  output logic [NumCh-1:0] irqFlag
);
  localparam int PadW = RegW - NumCh;

  armStrobe_t strobe;

  dmaArmDecode u_decode (
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .tcReached (tcReached),
    .repeatMode(repeatMode),
    .irqMask   (irqMask),
    .armCur    (armState),
    .strobe    (strobe)
  );

  dmaArmState u_state (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .irqClr  (irqClr),
    .armCur  (armState),
    .abortCur(abortPulse),
    .irqCur  (irqFlag)
  );

  assign regRdData = {{PadW{1'b0}}, armState};
  assign xferEn    = xferReq & armState;
endmodule

// File: rtl/dmaArmChk.sv
module dmaArmChk
  import dmaArmPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [RegW-1:0]  regWrData,
  input logic [NumCh-1:0] xferEn,
  input logic [NumCh-1:0] tcReached,
  input logic [NumCh-1:0] repeatMode,
  input logic [NumCh-1:0] irqMask,
  input logic [NumCh-1:0] irqClr,
  input logic [NumCh-1:0] armState,
  input logic [NumCh-1:0] abortPulse,
  input logic [NumCh-1:0] irqFlag
);
  AST_XFER_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (xferEn & ~armState) == '0); // R3

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[AbortBit]) |=> abortPulse == $past(regWrData[NumCh-1:0])); // R5

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regWrData[AbortBit]) |=> abortPulse == '0); // R5

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|(tcReached & armState & ~repeatMode)) |=>
      (armState & $past(tcReached & armState & ~repeatMode)) == '0); // R11

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((|(tcReached & armState & repeatMode)) && !regWrEn) |=>
      (~armState & $past(tcReached & armState & repeatMode)) == '0); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqFlag & ~$past(irqFlag) & ~$past(irqMask)) == '0); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(irqFlag & ~irqClr) & ~irqFlag) == '0); // R10
endmodule

bind dmaArmCtrl dmaArmChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .xferEn    (xferEn),
  .tcReached (tcReached),
  .repeatMode(repeatMode),
  .irqMask   (irqMask),
  .irqClr    (irqClr),
  .armState  (armState),
  .abortPulse(abortPulse),
  .irqFlag   (irqFlag)
);

// File: tb/dmaArmCtrl_tb.sv
module dmaArmCtrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [4:0] xferReq = '0, xferEn;
  logic [4:0] tcReached = '0, repeatMode = '0, irqMask = '0, irqClr = '0;
  logic [4:0] armState, abortPulse, irqFlag;

  always #5 clk = ~clk;

  dmaArmCtrl u_dut (.*);

  typedef struct {
    logic [4:0] arm;
    logic [4:0] irq;
    logic [4:0] ab;
    string      tag;
  } expItem_t;

  expItem_t   sbQ[$];
  logic [4:0] mArm = '0, mIrq = '0;
  int         nRun = 0, nFail = 0;
  bit         done = 0;

  // monitor: compares outputs just after each active edge
  always @(posedge clk) begin
    #1;
    if (sbQ.size() > 0) begin
      expItem_t e;
      e = sbQ.pop_front();
      nRun++;
      if (armState !== e.arm || irqFlag !== e.irq || abortPulse !== e.ab ||
          regRdData !== {3'b000, e.arm}) begin
        nFail++;
        $display("FAIL %s: arm=%b irq=%b abort=%b rd=%h expected arm=%b irq=%b abort=%b rd=%h",
                 e.tag, armState, irqFlag, abortPulse, regRdData,
                 e.arm, e.irq, e.ab, {3'b000, e.arm});
      end
    end
  end

  task automatic cyc(input bit w, input logic [7:0] d, input logic [4:0] tc,
                     input logic [4:0] rep, input logic [4:0] msk,
                     input logic [4:0] clr, input string tag);
    logic [4:0] ev, nArm;
    expItem_t   e;
    @(negedge clk);
    regWrEn = w; regWrData = d; tcReached = tc; repeatMode = rep;
    irqMask = msk; irqClr = clr;
    ev   = tc & mArm;
    nArm = mArm;
    if (w) nArm = d[7] ? (mArm & ~d[4:0]) : d[4:0];
    nArm = nArm & ~(ev & ~rep);
    e.irq = (mIrq & ~clr) | (ev & msk);
    e.arm = nArm;
    e.ab  = (w && d[7]) ? d[4:0] : 5'b0;
    e.tag = tag;
    mArm = nArm;
    mIrq = e.irq;
    sbQ.push_back(e);
  endtask

  task automatic chkXfer(input logic [4:0] req, input string tag);
    @(negedge clk);
    regWrEn = 0; tcReached = '0; irqClr = '0;
    xferReq = req;
    #1;
    nRun++;
    if (xferEn !== (req & mArm)) begin
      nFail++;
      $display("FAIL %s: xferEn=%b expected %b", tag, xferEn, req & mArm);
    end
    xferReq = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    cyc(0, 8'h00, 0, 0, 0, 0, "R1 reset state");
    cyc(1, 8'h15, 0, 0, 0, 0, "R2 load arm 10101");
    cyc(1, 8'h7F, 0, 0, 0, 0, "R2 load all, bits 6:5 read 0");
    chkXfer(5'b10110, "R3 gate all armed");
    cyc(1, 8'h85, 0, 0, 0, 0, "R4 R5 abort ch0 ch2");
    cyc(0, 8'h00, 0, 0, 0, 0, "R5 abort pulse gone");
    chkXfer(5'b11111, "R3 gate partial arm");
    cyc(0, 8'h00, 5'b00010, 5'b00000, 5'b11111, 0, "R6 R9 tc ch1 one-shot");
    cyc(0, 8'h00, 5'b01000, 5'b01000, 5'b00000, 0, "R7 R9 tc ch3 repeat masked");
    cyc(0, 8'h00, 5'b00001, 5'b00000, 5'b11111, 0, "R8 tc unarmed ch0");
    cyc(0, 8'h00, 0, 0, 0, 0, "R10 flag sticky");
    cyc(0, 8'h00, 0, 0, 0, 5'b00010, "R10 clear ch1");
    cyc(0, 8'h00, 5'b10000, 5'b00000, 5'b10000, 5'b10000, "R10 set beats clear ch4");
    cyc(1, 8'h1F, 0, 0, 0, 0, "R2 rearm all");
    cyc(1, 8'h1F, 5'b01000, 5'b00000, 5'b00000, 0, "R11 autoclear beats write ch3");
    cyc(1, 8'h9F, 0, 0, 0, 0, "R4 abort all");
    cyc(0, 8'h00, 0, 0, 0, 5'b11111, "R5 R10 idle after abort");
    chkXfer(5'b11111, "R3 gate none armed");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule